// File: doc/BRIEF.md
# Pointer-Register Address Generation Unit

This unit forms the addresses of indirect memory accesses made through three 16-bit pointer pairs held in byte-wide registers. For each request it takes the kind of access (data load, data store, program-memory byte read, or program-memory byte read extended by a page register), the pointer pair, the addressing mode and a 6-bit displacement. Alongside the request it takes the current pointer bytes and page register value, which the surrounding pipeline reads from its register file.

One cycle after a request, the unit returns a registered response. The response holds the effective data or program byte address, the register index that the pointer's low byte is written back to, and the updated pointer and page values with their write enables. It also returns the number of execution cycles the access costs. The memories and the register file stay outside the unit. The unit is combinational decode plus a single register stage, so a new request can be accepted on every cycle.

Top module: `ptr_agu`

## Requirements
- R1: `reqPtr` selects the pair: 0 = X (low byte register 26, high 27), 1 = Y (28/29), 2 = Z (30/31), and 3 is treated as Z. `ptrRegIdx` reports the low-byte register index. Program reads always use Z, whatever `reqPtr` holds.
- R2: `reqKind` encodes 0 = data load, 1 = data store, 2 = program read, 3 = extended program read. A request sampled on a rising edge gives its response after that edge, with `rspValid` high. In a cycle with no response, every response output is zero, and so are all outputs during reset.
- R3: `reqMode` 0 (plain) addresses the pointer itself. It raises no pointer write, and `newPtrHi:newPtrLo` equals the unchanged pointer.
- R4: `reqMode` 1 (post-increment) addresses the old pointer and writes back pointer+1, so 0xFFFF becomes 0x0000.
- R5: `reqMode` 2 (pre-decrement) addresses pointer−1 and writes that same value back, so 0x0000 becomes 0xFFFF.
- R6: `reqMode` 3 (displacement) on Y or Z addresses (pointer + `reqDisp`) mod 2^16 and does not write the pointer. On X the displacement is ignored and the access behaves as plain.
- R7: Data loads cost 1 cycle for plain, 2 for post-increment, 3 for pre-decrement and 3 for displacement.
- R8: Data stores cost 1 cycle for plain, 1 for post-increment, 2 for pre-decrement and 2 for displacement. A displacement on X costs the plain count for both loads and stores.
- R9: A program read returns byte address Z on `progAddr` with `dataAddr` zero and costs 3 cycles. Mode 1 writes back Z+1. Modes 2 and 3 behave as plain. A non-extended read never writes the page register.
- R10: An extended program read places the masked page register above Z in `progAddr`. With mode 1 it raises `pageWrEn`, and if Z was 0xFFFF it increments the page. Data requests report `progAddr` zero.
- R11: The page mask is (2·`PROG_WORDS` / 65536) − 1, which is 3 for the default 131072 words. `newPage` is always the masked page, after any increment, so an extended post-increment at page 3 with Z = 0xFFFF gives page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | Access kind (R2 encoding) |
| reqPtr | input | 2 | Pointer pair select (R1 encoding) |
| reqMode | input | 2 | Addressing mode (R3–R6 encoding) |
| reqDisp | input | 6 | Displacement |
| ptrLo | input | 8 | Low byte of the selected pointer |
| ptrHi | input | 8 | High byte of the selected pointer |
| pageIn | input | 8 | Current page register |
| rspValid | output | 1 | Response valid |
| dataAddr | output | 16 | Effective data byte address |
| progAddr | output | PROG_AW (18) | Effective program byte address |
| ptrWrEn | output | 1 | Pointer write-back enable |
| ptrRegIdx | output | 5 | Register index of the pointer low byte |
| newPtrLo | output | 8 | Updated pointer low byte |
| newPtrHi | output | 8 | Updated pointer high byte |
| pageWrEn | output | 1 | Page register write-back enable |
| newPage | output | 8 | Updated page register |
| cycles | output | 2 | Execution cycles of the access |

## Verification
Every response output is due exactly one rising edge after the request is sampled, since a single register stage lies between them. The bench drives each request on a falling edge. On the next falling edge it compares the whole response against a model built from the requirements, then drives the following request. Back-to-back requests and idle gaps therefore both check that each result appears in its own cycle and that nothing lingers for a further cycle. Pointer wraps at both ends, displacement overflow and page wrap each have their own vectors.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD     = 2'd0,
    KIND_STORE    = 2'd1,
    KIND_PROG     = 2'd2,
    KIND_PROG_EXT = 2'd3
  } access_kind_e;

  typedef enum logic [1:0] {
    MODE_PLAIN    = 2'd0,
    MODE_POST_INC = 2'd1,
    MODE_PRE_DEC  = 2'd2,
    MODE_DISP     = 2'd3
  } addr_mode_e;

  localparam logic [1:0] PAIR_X = 2'd0;
  localparam logic [1:0] PAIR_Z = 2'd2;

  // cycle cost per access class
  localparam logic [1:0] CYC_LD_PLAIN = 2'd1;
  localparam logic [1:0] CYC_LD_POST  = 2'd2;
  localparam logic [1:0] CYC_LD_PRE   = 2'd3;
  localparam logic [1:0] CYC_LD_DISP  = 2'd3;
  localparam logic [1:0] CYC_ST_PLAIN = 2'd1;
  localparam logic [1:0] CYC_ST_POST  = 2'd1;
  localparam logic [1:0] CYC_ST_PRE   = 2'd2;
  localparam logic [1:0] CYC_ST_DISP  = 2'd2;
  localparam logic [1:0] CYC_PROG     = 2'd3;

  typedef struct packed {
    logic       isProg;
    logic       isExt;
    logic       addDisp;
    logic       preDec;
    logic       postInc;
    logic [1:0] pairSel;
    logic [1:0] cycles;
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import ptr_agu_pkg::*;
(
  input  logic [1:0]  reqKind,
  input  logic [1:0]  reqPtr,
  input  logic [1:0]  reqMode,
  output agu_strobe_t strb
);

  access_kind_e kind;
  addr_mode_e   mode;
  logic         isStore;

  assign kind    = access_kind_e'(reqKind);
  assign mode    = addr_mode_e'(reqMode);
  assign isStore = (kind == KIND_STORE);

  always_comb begin
    strb        = '0;
    strb.isProg = (kind == KIND_PROG) || (kind == KIND_PROG_EXT);
    strb.isExt  = (kind == KIND_PROG_EXT);
    if (strb.isProg || reqPtr == 2'd3) strb.pairSel = PAIR_Z;
    else                               strb.pairSel = reqPtr;

    if (strb.isProg) begin
      // program reads: only post-increment changes Z, others are plain
      strb.postInc = (mode == MODE_POST_INC);
      strb.cycles  = CYC_PROG;
    end else begin
      unique case (mode)
        MODE_PLAIN: begin
          strb.cycles = isStore ? CYC_ST_PLAIN : CYC_LD_PLAIN;
        end
        MODE_POST_INC: begin
          strb.postInc = 1'b1;
          strb.cycles  = isStore ? CYC_ST_POST : CYC_LD_POST;
        end
        MODE_PRE_DEC: begin
          strb.preDec = 1'b1;
          strb.cycles = isStore ? CYC_ST_PRE : CYC_LD_PRE;
        end
        MODE_DISP: begin
          if (strb.pairSel == PAIR_X) begin
            strb.cycles = isStore ? CYC_ST_PLAIN : CYC_LD_PLAIN;
          end else begin
            strb.addDisp = 1'b1;
            strb.cycles  = isStore ? CYC_ST_DISP : CYC_LD_DISP;
          end
        end
        default: strb.cycles = CYC_LD_PLAIN;
      endcase
    end
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import ptr_agu_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int DISP_W    = 6,
  parameter int PAGE_W    = 8,
  parameter int PROG_AW   = 18,
  parameter int PAGE_MASK = 3,
  parameter int REG_IDX_W = 5,
  parameter int REG_BASE  = 26
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  agu_strobe_t           strb,
  input  logic [PTR_W/2-1:0]    ptrLo,
  input  logic [PTR_W/2-1:0]    ptrHi,
  input  logic [DISP_W-1:0]     reqDisp,
  input  logic [PAGE_W-1:0]     pageIn,
  output logic                  rspValid,
  output logic [PTR_W-1:0]      dataAddr,
  output logic [PROG_AW-1:0]    progAddr,
  output logic                  ptrWrEn,
  output logic [REG_IDX_W-1:0]  ptrRegIdx,
  output logic [PTR_W/2-1:0]    newPtrLo,
  output logic [PTR_W/2-1:0]    newPtrHi,
  output logic                  pageWrEn,
  output logic [PAGE_W-1:0]     newPage,
  output logic [1:0]            cycles
);

  localparam int BYTE_W = PTR_W / 2;
  localparam logic [PAGE_W-1:0] MASK_V = PAGE_W'(PAGE_MASK);

  logic [PTR_W-1:0]   ptr, ptrInc, ptrDec, ptrDisp, effPtr, nextPtr;
  logic               carryOut;
  logic [PAGE_W-1:0]  pageMasked, pageUsed, nextPage;
  logic [PROG_AW-1:0] progFull;
  logic [REG_IDX_W-1:0] regIdx;

  assign ptr      = {ptrHi, ptrLo};
  assign ptrInc   = ptr + 1'b1;
  assign ptrDec   = ptr - 1'b1;
  assign ptrDisp  = ptr + PTR_W'(reqDisp);
  assign carryOut = &ptr;

  assign effPtr  = strb.preDec ? ptrDec : (strb.addDisp ? ptrDisp : ptr);
  assign nextPtr = strb.postInc ? ptrInc : (strb.preDec ? ptrDec : ptr);

  assign pageMasked = pageIn & MASK_V;
  assign pageUsed   = strb.isExt ? pageMasked : '0;
  assign nextPage   = (strb.isExt && strb.postInc)
                    ? ((pageIn + PAGE_W'(carryOut)) & MASK_V)
                    : pageMasked;

  generate
    if (PROG_AW > PTR_W) begin : g_paged
      assign progFull = {pageUsed[PROG_AW-PTR_W-1:0], effPtr};
    end else begin : g_flat
      assign progFull = effPtr[PROG_AW-1:0];
    end
  endgenerate

  assign regIdx = REG_IDX_W'(REG_BASE) + REG_IDX_W'({strb.pairSel, 1'b0});

  always_ff @(posedge clk) begin
    if (!rstN || !reqValid) begin
      rspValid  <= 1'b0;
      dataAddr  <= '0;
      progAddr  <= '0;
      ptrWrEn   <= 1'b0;
      ptrRegIdx <= '0;
      newPtrLo  <= '0;
      newPtrHi  <= '0;
      pageWrEn  <= 1'b0;
      newPage   <= '0;
      cycles    <= '0;
    end else begin
      rspValid  <= 1'b1;
      dataAddr  <= strb.isProg ? '0 : effPtr;
      progAddr  <= strb.isProg ? progFull : '0;
      ptrWrEn   <= strb.postInc | strb.preDec;
      ptrRegIdx <= regIdx;
      newPtrLo  <= nextPtr[BYTE_W-1:0];
      newPtrHi  <= nextPtr[PTR_W-1:BYTE_W];
      pageWrEn  <= strb.isExt & strb.postInc;
      newPage   <= nextPage;
      cycles    <= strb.cycles;
    end
  end

  // R2: a response only follows a sampled request
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));

  // R2: outputs quiet without a response
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (cycles == 2'd0 && !ptrWrEn && !pageWrEn && dataAddr == '0));

  // R10: a page update always comes with a Z update
  a_r10_page_with_ptr: assert property (@(posedge clk) disable iff (!rstN)
    pageWrEn |-> (ptrWrEn && rspValid));

  // R11: page never leaves the masked range
  a_r11_page_bound: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (newPage <= MASK_V));

  // R7: every access costs at least one cycle
  a_r7_cycle_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (cycles != 2'd0));

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_agu_pkg::*;
#(
  parameter int PROG_WORDS = 131072,
  parameter int DISP_W     = 6,
  parameter int PAGE_W     = 8,
  localparam int PTR_W     = 16,
  localparam int BYTE_W    = PTR_W / 2,
  localparam int PROG_AW   = $clog2(PROG_WORDS * 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic [1:0]         reqPtr,
  input  logic [1:0]         reqMode,
  input  logic [DISP_W-1:0]  reqDisp,
  input  logic [BYTE_W-1:0]  ptrLo,
  input  logic [BYTE_W-1:0]  ptrHi,
  input  logic [PAGE_W-1:0]  pageIn,
  output logic               rspValid,
  output logic [PTR_W-1:0]   dataAddr,
  output logic [PROG_AW-1:0] progAddr,
  output logic               ptrWrEn,
  output logic [4:0]         ptrRegIdx,
  output logic [BYTE_W-1:0]  newPtrLo,
  output logic [BYTE_W-1:0]  newPtrHi,
  output logic               pageWrEn,
  output logic [PAGE_W-1:0]  newPage,
  output logic [1:0]         cycles
);

  localparam int PAGE_COUNT = (PROG_WORDS * 2) / (1 << PTR_W);
  localparam int PAGE_MASK  = (PAGE_COUNT > 1) ? PAGE_COUNT - 1 : 0;

  agu_strobe_t strb;

  agu_ctrl u_ctrl (
    .reqKind (reqKind),
    .reqPtr  (reqPtr),
    .reqMode (reqMode),
    .strb    (strb)
  );

  agu_datapath #(
    .PTR_W     (PTR_W),
    .DISP_W    (DISP_W),
    .PAGE_W    (PAGE_W),
    .PROG_AW   (PROG_AW),
    .PAGE_MASK (PAGE_MASK),
    .REG_IDX_W (5),
    .REG_BASE  (26)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .strb      (strb),
    .ptrLo     (ptrLo),
    .ptrHi     (ptrHi),
    .reqDisp   (reqDisp),
    .pageIn    (pageIn),
    .rspValid  (rspValid),
    .dataAddr  (dataAddr),
    .progAddr  (progAddr),
    .ptrWrEn   (ptrWrEn),
    .ptrRegIdx (ptrRegIdx),
    .newPtrLo  (newPtrLo),
    .newPtrHi  (newPtrHi),
    .pageWrEn  (pageWrEn),
    .newPage   (newPage),
    .cycles    (cycles)
  );

endmodule

// File: tb/ptr_agu_tb.sv
module ptr_agu_tb;

  localparam int PROG_WORDS = 131072;
  localparam int PROG_AW    = $clog2(PROG_WORDS * 2);
  localparam int PMASK      = ((PROG_WORDS * 2) / 65536 > 1) ? (PROG_WORDS * 2) / 65536 - 1 : 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = '0, reqPtr = '0, reqMode = '0;
  logic [5:0] reqDisp = '0;
  logic [7:0] ptrLo = '0, ptrHi = '0, pageIn = '0;
  logic rspValid, ptrWrEn, pageWrEn;
  logic [15:0] dataAddr;
  logic [PROG_AW-1:0] progAddr;
  logic [4:0] ptrRegIdx;
  logic [7:0] newPtrLo, newPtrHi, newPage;
  logic [1:0] cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected response of the request driven one cycle earlier
  int eValid, eData, eProg, eWr, eIdx, ePtr, ePw, ePage, eCyc;
  string eTag = "R2";

  always #4 clk = ~clk;

  ptr_agu #(.PROG_WORDS(PROG_WORDS)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqPtr(reqPtr), .reqMode(reqMode), .reqDisp(reqDisp),
    .ptrLo(ptrLo), .ptrHi(ptrHi), .pageIn(pageIn),
    .rspValid(rspValid), .dataAddr(dataAddr), .progAddr(progAddr),
    .ptrWrEn(ptrWrEn), .ptrRegIdx(ptrRegIdx), .newPtrLo(newPtrLo),
    .newPtrHi(newPtrHi), .pageWrEn(pageWrEn), .newPage(newPage),
    .cycles(cycles)
  );

  task automatic compare();
    int aPtr;
    aPtr = {newPtrHi, newPtrLo};
    checks++;
    if (rspValid !== 1'(eValid) || int'(dataAddr) != eData || int'(progAddr) != eProg ||
        ptrWrEn !== 1'(eWr) || int'(ptrRegIdx) != eIdx || aPtr != ePtr ||
        pageWrEn !== 1'(ePw) || int'(newPage) != ePage || int'(cycles) != eCyc) begin
      errors++;
      $display("FAIL %s: actual v=%0d d=%h p=%h wr=%0d idx=%0d np=%h pw=%0d pg=%0d cyc=%0d expected v=%0d d=%h p=%h wr=%0d idx=%0d np=%h pw=%0d pg=%0d cyc=%0d",
               eTag, rspValid, dataAddr, progAddr, ptrWrEn, ptrRegIdx, aPtr, pageWrEn, newPage, cycles,
               eValid, eData, eProg, eWr, eIdx, ePtr, ePw, ePage, eCyc);
    end
  endtask

  task automatic model(input bit v, input int kind, sel, mode, disp, ptr, page);
    int se;
    bit isProg, ext;
    eValid = v; eData = 0; eProg = 0; eWr = 0; eIdx = 0; ePtr = 0; ePw = 0; ePage = 0; eCyc = 0;
    if (!v) return;
    isProg = (kind >= 2);
    ext    = (kind == 3);
    se     = isProg ? 2 : ((sel == 3) ? 2 : sel);
    eIdx   = 26 + 2 * se;
    ePage  = page & PMASK;
    ePtr   = ptr;
    if (isProg) begin
      eProg = (ext ? (page & PMASK) * 65536 : 0) + ptr;
      eCyc  = 3;
      if (mode == 1) begin
        eWr  = 1;
        ePtr = (ptr + 1) % 65536;
        if (ext) begin
          ePw = 1;
          if (ptr == 65535) ePage = (page + 1) & PMASK;
        end
      end
    end else begin
      case (mode)
        0: begin eData = ptr; eCyc = 1; end
        1: begin eData = ptr; eWr = 1; ePtr = (ptr + 1) % 65536; eCyc = (kind == 1) ? 1 : 2; end
        2: begin ePtr = (ptr + 65535) % 65536; eData = ePtr; eWr = 1; eCyc = (kind == 1) ? 2 : 3; end
        default: begin
          if (se == 0) begin eData = ptr; eCyc = 1; end
          else begin eData = (ptr + disp) % 65536; eCyc = (kind == 1) ? 2 : 3; end
        end
      endcase
    end
  endtask

  task automatic step(input bit v, input int kind, sel, mode, disp, ptr, page, input string tag);
    @(negedge clk);
    compare();
    reqValid = v;
    reqKind  = 2'(kind);
    reqPtr   = 2'(sel);
    reqMode  = 2'(mode);
    reqDisp  = 6'(disp);
    ptrLo    = 8'(ptr);
    ptrHi    = 8'(ptr >> 8);
    pageIn   = 8'(page);
    model(v, kind, sel, mode, disp, ptr, page);
    eTag = tag;
  endtask

  initial begin
    model(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    compare();                                       // R2 reset state
    @(negedge clk);
    rstN = 1'b1;
    // kind, sel, mode, disp, ptr, page
    step(1, 0, 0, 0, 0, 16'h00c0, 0, "R1");          // X plain load
    step(1, 0, 1, 0, 0, 16'h00c0, 0, "R1");          // Y
    step(1, 0, 2, 0, 0, 16'h00cc, 0, "R1");          // Z
    step(1, 0, 3, 0, 0, 16'h1234, 0, "R1");          // code 3 -> Z
    step(1, 1, 1, 0, 0, 16'h009a, 2, "R3");          // plain store Y
    step(0, 0, 0, 0, 0, 0, 0, "R2");                 // idle
    step(1, 0, 0, 1, 0, 16'h00c0, 0, "R4");          // X+ load
    step(1, 1, 2, 1, 0, 16'h0155, 0, "R4");          // Z+ store
    step(1, 0, 1, 1, 0, 16'hffff, 0, "R4");          // wrap
    step(1, 0, 1, 2, 0, 16'h0099, 0, "R5");          // -Y load
    step(1, 1, 2, 2, 0, 16'h00ff, 0, "R5");          // -Z store
    step(1, 1, 0, 2, 0, 16'h0000, 0, "R5");          // wrap
    step(1, 0, 1, 3, 2, 16'h0080, 0, "R6");          // Y+2 load
    step(1, 0, 2, 3, 31, 16'h0080, 0, "R6");         // Z+31 load
    step(1, 1, 1, 3, 17, 16'h009a, 0, "R6");         // Y+17 store
    step(1, 0, 2, 3, 63, 16'hfff0, 0, "R6");         // displacement overflow
    step(1, 0, 0, 3, 5, 16'h0040, 0, "R6");          // X displacement ignored
    step(1, 1, 0, 3, 9, 16'h0040, 0, "R8");          // X displacement store
    step(1, 1, 0, 0, 0, 16'h0010, 0, "R8");
    step(1, 1, 0, 1, 0, 16'h0010, 0, "R8");
    step(1, 0, 2, 2, 0, 16'h0010, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 2, 0, 0, 0, 16'h0080, 1, "R9");          // byte read, X ignored
    step(1, 2, 2, 1, 0, 16'h0080, 0, "R9");          // Z+
    step(1, 2, 2, 1, 0, 16'hffff, 2, "R9");          // no page change
    step(1, 2, 2, 2, 0, 16'h0044, 0, "R9");          // predec as plain
    step(1, 2, 2, 3, 7, 16'h0044, 0, "R9");          // disp as plain
    step(1, 3, 2, 0, 0, 16'h0050, 2, "R10");         // page 2
    step(1, 3, 2, 0, 0, 16'h0011, 1, "R10");
    step(1, 3, 2, 1, 0, 16'hffff, 2, "R10");         // carry into page
    step(1, 3, 2, 1, 0, 16'h1000, 1, "R10");         // no carry
    step(1, 3, 2, 1, 0, 16'hffff, 3, "R11");         // page wraps 3 -> 0
    step(1, 3, 2, 0, 0, 16'h0010, 7, "R11");         // bits above mask dropped
    step(1, 0, 0, 0, 0, 16'h0001, 6, "R11");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, "R2");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2: watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule